// File: doc/BRIEF.md
# Sleep Entry and Watchdog Status Controller

This block lets a small 8-bit processor core put itself into a low-power sleep state. It runs the core's four-phase instruction cycle, watches the instruction word presented in the decode phase, and recognises the single sleep opcode. While that instruction executes, the block clears the watchdog counter and its postscaler, sets the time-out flag and clears the power-down flag. At the end of the instruction cycle it drops the core clock enable.

The watchdog counts ticks from a free-running enable input, so it keeps counting while the core clock is gated. A watchdog overflow during sleep wakes the core and clears the time-out flag. An external wake request also wakes the core but leaves the time-out flag alone. A watchdog overflow while the core is running raises a one-cycle core reset request instead, and also clears the time-out flag.

Top module: `sleep_wdt_ctl`

## Requirements
- R1: After reset, coreClkEn=1, timeoutFlag=1, powerDnFlag=1, coreRst=0, wdtCount=0 and qPhase=0.
- R2: While awake, qPhase steps 0,1,2,3,0 on every clock. Phase 0 is decode, 1 is idle, 2 is execute and 3 is commit. While asleep, qPhase holds at 0.
- R3: Only the exact word 16'h0003, sampled while qPhase=0, starts a sleep. Other words, including 16'h0013, 16'h8003 and 16'h0002, have no effect: coreClkEn and powerDnFlag stay 1.
- R4: At the clock edge that ends phase 2 of the sleep instruction, the watchdog counter and postscaler become zero, timeoutFlag becomes 1 and powerDnFlag becomes 0. The clear takes priority over a watchdog tick on the same edge.
- R5: coreClkEn falls at the edge that ends phase 3 of the sleep instruction and stays low until a wake. qPhase stays 0 throughout.
- R6: The watchdog overflows on the 256*2^psSel-th tick after a clear, for psSel from 0 to 7. wdtCount shows the ticks divided by the postscaler ratio, modulo 256.
- R7: An overflow while asleep sets coreClkEn to 1 on the next edge, with qPhase=0. That same edge clears timeoutFlag. coreRst stays 0.
- R8: An external wake request while asleep sets coreClkEn to 1 on the next edge and leaves timeoutFlag unchanged.
- R9: An overflow while awake drives coreRst high for exactly one cycle, starting the cycle after the overflowing tick. timeoutFlag goes to 0 on the following edge.
- R10: Once cleared, powerDnFlag returns to 1 only through reset. No kind of wake sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instrWord | input | 16 | Instruction word, sampled in phase 0 |
| extWake | input | 1 | External wake request, acted on only while asleep |
| wdtTick | input | 1 | Free-running watchdog count enable |
| psSel | input | 3 | Postscaler ratio select, ratio = 2^psSel |
| coreClkEn | output | 1 | Clock enable for the core |
| coreRst | output | 1 | One-cycle core reset request on an awake overflow |
| timeoutFlag | output | 1 | Time-out status flag |
| powerDnFlag | output | 1 | Power-down status flag |
| wdtCount | output | 8 | Current watchdog counter value |
| qPhase | output | 2 | Current instruction phase |

## Verification
The bench checks that a watchdog tick landing on the same edge as the sleep clear is lost. A design that let the tick win would show a count of 1 instead of 0. It runs the same overflow once awake and once asleep. A design that mixed up the two cases would pulse coreRst during sleep, or would wake without clearing the time-out flag. It drives near-miss opcodes that differ by one bit. A loose decoder would gate the clock on one of them. It also checks an external wake, where a design that cleared the time-out flag on any wake would report 0. Finally it runs postscaler ratios of 1, 4 and 128, which show whether the select is applied as a power of two.

// File: rtl/sleepwdt_pkg.sv
package sleepwdt_pkg;

  // Instruction phases of one core cycle; the numeric order is the sequence.
  typedef enum logic [1:0] {
    PH_0 = 2'd0,  // decode
    PH_1 = 2'd1,  // idle
    PH_2 = 2'd2,  // execute
    PH_3 = 2'd3   // commit / sleep entry
  } phase_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic wdtClr;  // clear watchdog counter and postscaler
    logic toSet;   // set the time-out flag
    logic pdClr;   // clear the power-down flag
  } slp_strb_t;

  function automatic phase_t phaseNext(phase_t cur);
    return phase_t'(cur + 2'd1);
  endfunction

endpackage

// File: rtl/slp_ctrl.sv
module slp_ctrl
  import sleepwdt_pkg::*;
#(
  parameter int                  INSTR_W  = 16,
  parameter logic [INSTR_W-1:0]  SLEEP_OP = INSTR_W'(3)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               extWake,
  input  logic               wdtOvf,
  output slp_strb_t          strb,
  output phase_t             phase,
  output logic               coreClkEn,
  output logic               coreRst
);

  logic sleeping;
  logic sleepPend;
  logic isSleepOp;
  logic wakeEvt;
  logic enterNow;

  assign isSleepOp = (instrWord == SLEEP_OP);
  assign wakeEvt   = wdtOvf || extWake;
  assign enterNow  = !sleeping && (phase == PH_3) && sleepPend;

  // Phase sequencer, opcode latch and sleep state.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_0;
      sleepPend <= 1'b0;
      sleeping  <= 1'b0;
    end else if (sleeping) begin
      phase <= PH_0;
      if (wakeEvt) begin
        sleeping <= 1'b0;
      end
    end else begin
      phase <= phaseNext(phase);
      if (phase == PH_0) begin
        sleepPend <= isSleepOp;
      end
      if (enterNow) begin
        sleeping  <= 1'b1;
        sleepPend <= 1'b0;
      end
    end
  end

  // Execute-phase strobes for the sleep instruction.
  always_comb begin
    strb        = '0;
    if (!sleeping && (phase == PH_2) && sleepPend) begin
      strb.wdtClr = 1'b1;
      strb.toSet  = 1'b1;
      strb.pdClr  = 1'b1;
    end
  end

  assign coreClkEn = !sleeping;
  assign coreRst   = wdtOvf && !sleeping;

  // R2: the phase advances by one each cycle while awake
  p_phase_adv_r2: assert property (@(posedge clk) disable iff (!rstN)
    coreClkEn |=> (phase == phaseNext($past(phase))));

  // R5: the clock stays gated only with the phase parked at 0
  p_hold_phase_r5: assert property (@(posedge clk) disable iff (!rstN)
    !coreClkEn |-> (phase == PH_0));

  // R5: commit phase of a pending sleep gates the clock
  p_enter_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_3) && sleepPend && coreClkEn) |=> !coreClkEn);

  // R7: a watchdog overflow while asleep wakes the core at phase 0
  p_wdt_wake_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!coreClkEn && wdtOvf) |=> (coreClkEn && (phase == PH_0)));

  // R8: an external request while asleep wakes the core
  p_ext_wake_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!coreClkEn && extWake) |=> coreClkEn);

endmodule

// File: rtl/slp_dp.sv
module slp_dp
  import sleepwdt_pkg::*;
#(
  parameter int WDT_W    = 8,
  parameter int PS_SEL_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wdtTick,
  input  logic [PS_SEL_W-1:0] psSel,
  input  slp_strb_t           strb,
  output logic                wdtOvf,
  output logic [WDT_W-1:0]    wdtCnt,
  output logic                timeoutFlag,
  output logic                powerDnFlag
);

  localparam int PS_W = (1 << PS_SEL_W) - 1;

  logic [PS_W-1:0] psCnt;
  logic [PS_W-1:0] psLimit;
  logic [PS_W:0]   psSpan;
  logic            psWrap;
  logic            cntTop;
  logic            ovfNext;

  assign psSpan  = (PS_W + 1)'(1) << psSel;
  assign psLimit = PS_W'(psSpan - 1'b1);
  assign psWrap  = (psCnt >= psLimit);
  assign cntTop  = &wdtCnt;
  assign ovfNext = wdtTick && psWrap && cntTop && !strb.wdtClr;

  // Postscaler feeds the watchdog counter; a clear strobe wins over a tick.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt  <= '0;
      wdtCnt <= '0;
    end else if (strb.wdtClr) begin
      psCnt  <= '0;
      wdtCnt <= '0;
    end else if (wdtTick) begin
      if (psWrap) begin
        psCnt  <= '0;
        wdtCnt <= wdtCnt + 1'b1;
      end else begin
        psCnt  <= psCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdtOvf <= 1'b0;
    end else begin
      wdtOvf <= ovfNext;
    end
  end

  // Status flags.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeoutFlag <= 1'b1;
      powerDnFlag <= 1'b1;
    end else begin
      if (strb.toSet) begin
        timeoutFlag <= 1'b1;
      end else if (wdtOvf) begin
        timeoutFlag <= 1'b0;
      end
      if (strb.pdClr) begin
        powerDnFlag <= 1'b0;
      end
    end
  end

  // R4: the execute strobe leaves counter zero and flags in sleep state
  p_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.wdtClr |=> ((wdtCnt == '0) && timeoutFlag && !powerDnFlag));

  // R6: an overflow is a single-cycle event
  p_ovf_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    wdtOvf |=> !wdtOvf);

  // R9: an overflow clears the time-out flag on the next edge
  p_ovf_to_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wdtOvf && !strb.toSet) |=> !timeoutFlag);

  // R10: the power-down flag never rises outside reset
  p_pd_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    !powerDnFlag |=> !powerDnFlag);

endmodule

// File: rtl/sleep_wdt_ctl.sv
module sleep_wdt_ctl
  import sleepwdt_pkg::*;
#(
  parameter int                 INSTR_W  = 16,
  parameter logic [INSTR_W-1:0] SLEEP_OP = INSTR_W'(3),
  parameter int                 WDT_W    = 8,
  parameter int                 PS_SEL_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [INSTR_W-1:0]  instrWord,
  input  logic                extWake,
  input  logic                wdtTick,
  input  logic [PS_SEL_W-1:0] psSel,
  output logic                coreClkEn,
  output logic                coreRst,
  output logic                timeoutFlag,
  output logic                powerDnFlag,
  output logic [WDT_W-1:0]    wdtCount,
  output logic [1:0]          qPhase
);

  slp_strb_t strb;
  phase_t    phase;
  logic      wdtOvf;

  slp_ctrl #(
    .INSTR_W  (INSTR_W),
    .SLEEP_OP (SLEEP_OP)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instrWord (instrWord),
    .extWake   (extWake),
    .wdtOvf    (wdtOvf),
    .strb      (strb),
    .phase     (phase),
    .coreClkEn (coreClkEn),
    .coreRst   (coreRst)
  );

  slp_dp #(
    .WDT_W    (WDT_W),
    .PS_SEL_W (PS_SEL_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .wdtTick     (wdtTick),
    .psSel       (psSel),
    .strb        (strb),
    .wdtOvf      (wdtOvf),
    .wdtCnt      (wdtCount),
    .timeoutFlag (timeoutFlag),
    .powerDnFlag (powerDnFlag)
  );

  assign qPhase = phase;

endmodule

// File: tb/test_sleep_wdt_ctl.sv
module test_sleep_wdt_ctl;

  localparam int DC = -1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] instrWord = '0;
  logic        extWake = 1'b0;
  logic        wdtTick = 1'b0;
  logic [2:0]  psSel = '0;
  logic        coreClkEn, coreRst, timeoutFlag, powerDnFlag;
  logic [7:0]  wdtCount;
  logic [1:0]  qPhase;

  int cyc = 0;
  int total = 0;
  int bad = 0;

  typedef struct {
    int    at;
    string req;
    int    ce;
    int    to;
    int    pd;
    int    rs;
    int    cn;
    int    ph;
  } exp_t;

  exp_t sbq[$];
  exp_t cur;

  sleep_wdt_ctl i_sleep_wdt_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .instrWord   (instrWord),
    .extWake     (extWake),
    .wdtTick     (wdtTick),
    .psSel       (psSel),
    .coreClkEn   (coreClkEn),
    .coreRst     (coreRst),
    .timeoutFlag (timeoutFlag),
    .powerDnFlag (powerDnFlag),
    .wdtCount    (wdtCount),
    .qPhase      (qPhase)
  );

  always #5 clk = ~clk;

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  task automatic expectAt(int at, string req, int ce, int to, int pd, int rs, int cn, int ph);
    exp_t e;
    e.at = at; e.req = req; e.ce = ce; e.to = to;
    e.pd = pd; e.rs = rs; e.cn = cn; e.ph = ph;
    sbq.push_back(e);
  endtask

  function automatic int fieldBad(string req, string nm, int act, int exp, int at);
    if (exp == DC || act == exp) return 0;
    $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, nm, at, act, exp);
    return 1;
  endfunction

  // Monitor: compares outputs with queued expectations between edges.
  always @(negedge clk) begin
    if (rstN) begin
      while (sbq.size() > 0 && sbq[0].at <= cyc) begin
        int nb;
        cur = sbq.pop_front();
        total++;
        nb = 0;
        if (cur.at != cyc) begin
          $display("FAIL %s scheduling: actual cycle=%0d expected cycle=%0d", cur.req, cyc, cur.at);
          nb++;
        end
        nb += fieldBad(cur.req, "coreClkEn",   int'(coreClkEn),   cur.ce, cyc);
        nb += fieldBad(cur.req, "timeoutFlag", int'(timeoutFlag), cur.to, cyc);
        nb += fieldBad(cur.req, "powerDnFlag", int'(powerDnFlag), cur.pd, cyc);
        nb += fieldBad(cur.req, "coreRst",     int'(coreRst),     cur.rs, cyc);
        nb += fieldBad(cur.req, "wdtCount",    int'(wdtCount),    cur.cn, cyc);
        nb += fieldBad(cur.req, "qPhase",      int'(qPhase),      cur.ph, cyc);
        if (nb != 0) bad++;
      end
    end
  end

  task automatic waitCyc(int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Presents the sleep word in phase 0; returns the cycle count at that point.
  task automatic doSleep(output int s);
    @(negedge clk);
    while (qPhase != 2'd0) @(negedge clk);
    s = cyc;
    instrWord = 16'h0003;
    @(negedge clk);
    instrWord = 16'h0000;
  endtask

  task automatic presentWord(logic [15:0] w);
    @(negedge clk);
    while (qPhase != 2'd0) @(negedge clk);
    instrWord = w;
    @(negedge clk);
    instrWord = 16'h0000;
  endtask

  initial begin
    int c0, s, s2, s3, s4, t, w, u;
    // R1: reset values
    expectAt(0, "R1", 1, 1, 1, 0, 0, 0);
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);

    // R2: phase sequence while awake
    expectAt(cyc + 1, "R2", 1, DC, DC, DC, DC, 1);
    expectAt(cyc + 2, "R2", 1, DC, DC, DC, DC, 2);
    expectAt(cyc + 3, "R2", 1, DC, DC, DC, DC, 3);
    expectAt(cyc + 4, "R2", 1, DC, DC, DC, DC, 0);
    waitCyc(cyc + 4);

    // R3: near-miss words are ignored
    presentWord(16'h0013);
    presentWord(16'h8003);
    presentWord(16'h0002);
    expectAt(cyc + 8, "R3", 1, 1, 1, 0, 0, DC);
    waitCyc(cyc + 8);

    // R6 and R9: overflow while awake, ratio 1
    @(negedge clk);
    c0 = cyc;
    psSel = 3'd0;
    wdtTick = 1'b1;
    expectAt(c0 + 100, "R6", 1, 1, DC, 0, 100, DC);
    expectAt(c0 + 255, "R9", 1, 1, DC, 0, 255, DC);
    expectAt(c0 + 256, "R9", 1, 1, DC, 1, 0, DC);
    expectAt(c0 + 257, "R9", 1, 0, 1, 0, 1, DC);
    waitCyc(c0 + 257);

    // R4, R5, R7, R10: sleep with ticks running, woken by the watchdog
    doSleep(s);
    expectAt(s + 3, "R4", 1, 1, 0, DC, 0, 3);
    expectAt(s + 4, "R5", 0, 1, 0, 0, 1, 0);
    expectAt(s + 259, "R7", 0, 1, 0, 0, 0, 0);
    expectAt(s + 260, "R7", 1, 0, 0, 0, 1, 0);
    expectAt(s + 261, "R2", 1, DC, 0, DC, DC, 1);
    waitCyc(s + 260);
    wdtTick = 1'b0;
    waitCyc(s + 262);

    // R8: external wake keeps the time-out flag
    doSleep(s2);
    expectAt(s2 + 3, "R4", 1, 1, 0, DC, 0, DC);
    expectAt(s2 + 4, "R5", 0, DC, DC, DC, DC, 0);
    expectAt(s2 + 24, "R5", 0, 1, 0, 0, 0, 0);
    w = s2 + 30;
    expectAt(w, "R8", 0, 1, 0, DC, DC, 0);
    expectAt(w + 1, "R8", 1, 1, 0, 0, DC, 0);
    expectAt(w + 2, "R2", 1, DC, DC, DC, DC, 1);
    waitCyc(w);
    extWake = 1'b1;
    @(negedge clk);
    extWake = 1'b0;
    waitCyc(w + 2);

    // R6 and R7: ratio 4 while asleep
    doSleep(s3);
    expectAt(s3 + 4, "R5", 0, 1, 0, DC, 0, DC);
    t = s3 + 5;
    expectAt(t + 40, "R6", 0, DC, DC, DC, 10, DC);
    expectAt(t + 1024, "R6", 0, 1, 0, 0, 0, DC);
    expectAt(t + 1025, "R7", 1, 0, 0, 0, DC, 0);
    waitCyc(t);
    psSel = 3'd2;
    wdtTick = 1'b1;
    waitCyc(t + 1025);
    wdtTick = 1'b0;

    // R6, R9, R10: ratio 128 while awake after an external wake
    doSleep(s4);
    expectAt(s4 + 4, "R5", 0, 1, 0, DC, 0, DC);
    waitCyc(s4 + 6);
    extWake = 1'b1;
    @(negedge clk);
    extWake = 1'b0;
    u = s4 + 8;
    expectAt(u + 640, "R6", 1, 1, DC, 0, 5, DC);
    expectAt(u + 32767, "R9", 1, 1, 0, 0, 255, DC);
    expectAt(u + 32768, "R9", 1, 1, 0, 1, 0, DC);
    expectAt(u + 32769, "R10", 1, 0, 0, 0, DC, DC);
    waitCyc(u);
    psSel = 3'd7;
    wdtTick = 1'b1;
    waitCyc(u + 32770);
    wdtTick = 1'b0;

    while (sbq.size() > 0) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule